// File: doc/BRIEF.md
# Packed AND-Test Mask Unit

This block is the predicate-producing test stage of a SIMD datapath. It receives two vector operands of up to 512 bits, cuts them into elements of 8, 16, 32 or 64 bits, ANDs each pair of elements and reports per element whether anything survived the AND. The answers are gathered into a 64-bit predicate mask, one bit per element, and the mask is the only result. The unit changes no condition flags.

Element size and active vector length (128, 256 or 512 bits) are chosen per operation, so the number of live mask lanes changes from 2 to 64. An optional zeroing writemask can force individual lanes to zero. For 32-bit and 64-bit elements whose second operand came from memory, a broadcast flag replicates the lowest element of the second operand across all lanes. The answer is registered once and travels with a valid strobe.

Top module: `tmask_unit`

## Requirements
- R1: For each live lane j, the mask bit is 1 when the bitwise AND of the lane's src1 element and its src2 element has any bit set, and 0 when the AND is all zero.
- R2: Lane j uses bits [j*E+E-1 : j*E] of each source, where E is the element width in bits; mask bit j belongs to lane j.
- R3: The element size code `elem_sz` is 0 for 8, 1 for 16, 2 for 32 and 3 for 64 bits. The vector length code `vec_len` is 0 for 128, 1 for 256 and 2 for 512 bits. The live lane count is (16 << vec_len) >> elem_sz, and every mask bit at or above that count is 0.
- R4: A `vec_len` code of 3 is reserved and gives an all-zero mask.
- R5: When `wm_en` is 1, every lane whose `wm` bit is 0 gives a 0 mask bit (lanes are zeroed, never merged with an old value).
- R6: When `wm_en` is 0, the `wm` value has no effect and every live lane is computed.
- R7: When `bcast` and `src2_mem` are both 1 and the element size is 32 or 64 bits, every lane tests its src1 element against the lowest element of src2 (bits E-1:0).
- R8: For 8-bit and 16-bit elements, or when `src2_mem` is 0, `bcast` has no effect and each lane uses its own slice of src2.
- R9: Source bits above the selected vector length have no effect on the mask.
- R10: `valid_out` equals `valid_in` of the previous clock, and `mask_out` carries the result of the operation presented in that cycle.
- R11: In a cycle with `valid_in` at 0, `mask_out` keeps its previous value on the next clock.
- R12: While `rst_n` is 0, `mask_out` and `valid_out` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low, released in step with clk |
| valid_in | input | 1 | Operation present this cycle |
| elem_sz | input | 2 | Element size code |
| vec_len | input | 2 | Vector length code |
| src1 | input | 512 | First vector operand |
| src2 | input | 512 | Second vector operand |
| src2_mem | input | 1 | Second operand was fetched from memory |
| bcast | input | 1 | Broadcast request for the second operand |
| wm_en | input | 1 | Apply the zeroing writemask |
| wm | input | 64 | Writemask, one bit per lane |
| valid_out | output | 1 | Registered result is fresh |
| mask_out | output | 64 | Registered predicate mask |

## Verification
The assertions take for granted that `rst_n` is released away from the clock edge, that the codes on `elem_sz` and `vec_len` are stable across the cycle in which `valid_in` is sampled, and that `valid_in` is low in the cycle that reset is released. The bench drives every input on the falling edge, holds `valid_in` low throughout reset and for two clocks after it, and changes operands only in cycles it then samples. It covers every element-size and vector-length code, including the reserved one, so the lane-clearing checks see each live count.

// File: rtl/tmask_pkg.sv
package tmask_pkg;

  typedef enum logic [1:0] {
    ESZ_B8  = 2'd0,
    ESZ_B16 = 2'd1,
    ESZ_B32 = 2'd2,
    ESZ_B64 = 2'd3
  } esz_e;

  typedef enum logic [1:0] {
    VLN_128  = 2'd0,
    VLN_256  = 2'd1,
    VLN_512  = 2'd2,
    VLN_RSVD = 2'd3
  } vlen_e;

endpackage

// File: rtl/tmask_elem_test.sv
// One fixed-width slicing of the operands: per-element AND-nonzero flags.
module tmask_elem_test #(
  parameter int unsigned DATA_W = 512,
  parameter int unsigned ELEM_W = 8
) (
  input  logic [DATA_W-1:0]        opa,
  input  logic [DATA_W-1:0]        opb,
  input  logic                     bcast_sel,
  output logic [DATA_W/ELEM_W-1:0] nz
);
  localparam int unsigned NUM_E = DATA_W / ELEM_W;

  for (genvar j = 0; j < NUM_E; j++) begin : g_elem
    logic [ELEM_W-1:0] b_elem;
    assign b_elem = bcast_sel ? opb[ELEM_W-1:0] : opb[j*ELEM_W +: ELEM_W];
    assign nz[j]  = |(opa[j*ELEM_W +: ELEM_W] & b_elem);
  end
endmodule

// File: rtl/tmask_lane_limit.sv
// Thermometer of live lanes from the element-size and vector-length codes.
module tmask_lane_limit
  import tmask_pkg::*;
#(
  parameter int unsigned MASK_W = 64,
  parameter int unsigned MIN_VL = 128
) (
  input  logic [1:0]        esz,
  input  logic [1:0]        vlen,
  output logic [MASK_W-1:0] lane_en
);
  localparam int unsigned BASE = MIN_VL / 8;
  localparam int unsigned KW   = $clog2(MASK_W) + 2;

  logic [KW-1:0] lane_cnt;

  always_comb begin
    if (vlen_e'(vlen) == VLN_RSVD) begin
      lane_cnt = '0;
    end else begin
      lane_cnt = (KW'(BASE) << vlen) >> esz;
    end
  end

  for (genvar i = 0; i < MASK_W; i++) begin : g_lane
    assign lane_en[i] = (KW'(i) < lane_cnt);
  end
endmodule

// File: rtl/tmask_unit.sv
module tmask_unit
  import tmask_pkg::*;
#(
  parameter int unsigned DATA_W = 512,
  parameter int unsigned MIN_VL = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid_in,
  input  logic [1:0]        elem_sz,
  input  logic [1:0]        vec_len,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic              src2_mem,
  input  logic              bcast,
  input  logic              wm_en,
  input  logic [DATA_W/8-1:0] wm,
  output logic              valid_out,
  output logic [DATA_W/8-1:0] mask_out
);
  localparam int unsigned MASK_W = DATA_W / 8;

  logic [MASK_W-1:0]    nz_b8;
  logic [MASK_W/2-1:0]  nz_b16;
  logic [MASK_W/4-1:0]  nz_b32;
  logic [MASK_W/8-1:0]  nz_b64;
  logic [MASK_W-1:0]    nz_sel;
  logic [MASK_W-1:0]    lane_en;
  logic [MASK_W-1:0]    wm_gate;
  logic [MASK_W-1:0]    mask_d, mask_q;
  logic                 valid_d, valid_q;
  logic                 bcast_wide;

  // broadcast is only honoured for wide elements taken from memory
  assign bcast_wide = bcast & src2_mem & elem_sz[1];

  tmask_elem_test #(.DATA_W(DATA_W), .ELEM_W(8)) u_b8 (
    .opa(src1), .opb(src2), .bcast_sel(1'b0), .nz(nz_b8));
  tmask_elem_test #(.DATA_W(DATA_W), .ELEM_W(16)) u_b16 (
    .opa(src1), .opb(src2), .bcast_sel(1'b0), .nz(nz_b16));
  tmask_elem_test #(.DATA_W(DATA_W), .ELEM_W(32)) u_b32 (
    .opa(src1), .opb(src2), .bcast_sel(bcast_wide), .nz(nz_b32));
  tmask_elem_test #(.DATA_W(DATA_W), .ELEM_W(64)) u_b64 (
    .opa(src1), .opb(src2), .bcast_sel(bcast_wide), .nz(nz_b64));

  tmask_lane_limit #(.MASK_W(MASK_W), .MIN_VL(MIN_VL)) u_limit (
    .esz(elem_sz), .vlen(vec_len), .lane_en(lane_en));

  always_comb begin
    unique case (esz_e'(elem_sz))
      ESZ_B8:  nz_sel = nz_b8;
      ESZ_B16: nz_sel = MASK_W'(nz_b16);
      ESZ_B32: nz_sel = MASK_W'(nz_b32);
      default: nz_sel = MASK_W'(nz_b64);
    endcase
  end

  assign wm_gate = wm_en ? wm : {MASK_W{1'b1}};

  // next-state
  always_comb begin
    valid_d = valid_in;
    mask_d  = mask_q;
    if (valid_in) begin
      mask_d = nz_sel & lane_en & wm_gate;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      mask_q  <= mask_d;
      valid_q <= valid_d;
    end
  end

  assign mask_out  = mask_q;
  assign valid_out = valid_q;
endmodule

// File: rtl/tmask_unit_chk.sv
module tmask_unit_chk #(
  parameter int unsigned DATA_W = 512
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 valid_in,
  input logic [1:0]           elem_sz,
  input logic [1:0]           vec_len,
  input logic [DATA_W-1:0]    src1,
  input logic                 wm_en,
  input logic [DATA_W/8-1:0]  wm,
  input logic                 valid_out,
  input logic [DATA_W/8-1:0]  mask_out
);
  localparam int unsigned MASK_W = DATA_W / 8;
  localparam int unsigned Q_LANES = MASK_W / 8;

  always @(posedge clk) begin
    if (!rst_n) begin
      AST_RESET_CLEAR: assert (mask_out == '0 && !valid_out); // R12
    end
  end

  AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_in |=> valid_out); // R10
  AST_VALID_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> !valid_out); // R10
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_in |=> $stable(mask_out)); // R11
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && vec_len == 2'd3) |=> (mask_out == '0)); // R4
  AST_QWORD_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && elem_sz == 2'd3) |=> ((mask_out >> Q_LANES) == '0)); // R3
  AST_ZEROING: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && wm_en) |=> ((mask_out & ~$past(wm)) == '0)); // R5
  AST_ZERO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_in && src1 == '0) |=> (mask_out == '0)); // R1
endmodule

bind tmask_unit tmask_unit_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .elem_sz(elem_sz),
  .vec_len(vec_len), .src1(src1), .wm_en(wm_en), .wm(wm),
  .valid_out(valid_out), .mask_out(mask_out));

// File: tb/tmask_unit_test.sv
`timescale 1ns/1ps
module tmask_unit_test;
  localparam int DW = 512;
  localparam int MW = 64;
  localparam int NV = 16;
  // entry: [15:12] seed a, [11:8] seed b, [7:6] elem_sz, [5:4] vec_len,
  //        [3] wm_en, [2] bcast, [1] src2_mem, [0] writemask pattern pick
  localparam logic [15:0] VEC [0:NV-1] = '{
    16'h1200, 16'h3410, 16'h5620, 16'h7840, 16'h9A50, 16'hBC60,
    16'hDE80, 16'hF190, 16'h23A0, 16'h45C0, 16'h67D0, 16'h89E9,
    16'hAB2B, 16'hCDA6, 16'hEFE7, 16'h1395
  };

  logic clk = 1'b0, rst_n = 1'b0, valid_in = 1'b0;
  logic [1:0] elem_sz = '0, vec_len = '0;
  logic [DW-1:0] src1 = '0, src2 = '0;
  logic src2_mem = 1'b0, bcast = 1'b0, wm_en = 1'b0;
  logic [MW-1:0] wm = '0;
  logic valid_out;
  logic [MW-1:0] mask_out;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  tmask_unit uut (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .elem_sz(elem_sz),
    .vec_len(vec_len), .src1(src1), .src2(src2), .src2_mem(src2_mem),
    .bcast(bcast), .wm_en(wm_en), .wm(wm), .valid_out(valid_out),
    .mask_out(mask_out));

  function automatic logic [DW-1:0] gen(input logic [3:0] s);
    logic [DW-1:0] r;
    for (int k = 0; k < DW/32; k++) begin
      logic [31:0] w;
      w = ((32'(s) + 32'd1) * 32'h2545F491) ^ (32'(k) * 32'h9E3779B9);
      r[k*32 +: 32] = w & (w >> 5) & (w << 3);
    end
    return r;
  endfunction

  function automatic logic [MW-1:0] model(input logic [DW-1:0] a,
      input logic [DW-1:0] b, input logic [1:0] es, input logic [1:0] vl,
      input logic we, input logic [MW-1:0] m, input logic bc, input logic mem);
    logic [MW-1:0] r = '0;
    int e = 8 << es;
    int kl = (vl == 2'd3) ? 0 : ((16 << vl) >> es);
    logic [63:0] em = (e == 64) ? '1 : ((64'd1 << e) - 64'd1);
    for (int j = 0; j < kl; j++) begin
      logic [63:0] ea, eb;
      ea = 64'(a >> (j*e)) & em;
      eb = (bc && mem && es >= 2) ? (64'(b) & em) : (64'(b >> (j*e)) & em);
      r[j] = ((ea & eb) != 0) && (!we || m[j]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [MW-1:0] got,
                       input logic [MW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(input logic [1:0] es, input logic [1:0] vl,
      input logic [DW-1:0] a, input logic [DW-1:0] b, input logic we,
      input logic [MW-1:0] m, input logic bc, input logic mem);
    elem_sz = es; vec_len = vl; src1 = a; src2 = b;
    wm_en = we; wm = m; bcast = bc; src2_mem = mem; valid_in = 1'b1;
    @(negedge clk);
    valid_in = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] ones, a, b;
    ones = '1;
    repeat (3) @(negedge clk);
    check("R12 reset mask", mask_out, '0);
    check("R12 reset valid", MW'(valid_out), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table walk (R1 R2 R3 R5 R6 R7 R8 R9 R10)
    for (int v = 0; v < NV; v++) begin
      logic [MW-1:0] m, exp;
      a = gen(VEC[v][15:12]);
      b = gen(VEC[v][11:8]);
      m = VEC[v][0] ? 64'hA5C3_0FF0_5A3C_F00F : 64'h0123_4567_89AB_CDEF;
      exp = model(a, b, VEC[v][7:6], VEC[v][5:4], VEC[v][3], m,
                  VEC[v][2], VEC[v][1]);
      run(VEC[v][7:6], VEC[v][5:4], a, b, VEC[v][3], m, VEC[v][2], VEC[v][1]);
      check("R1 R2 R3 R5 table", mask_out, exp);
      check("R10 valid follows", MW'(valid_out), 64'd1);
    end

    // R1: byte 0 no overlap, byte 1 shares bit 0
    a = '0; b = '0; a[7:0] = 8'h0F; b[7:0] = 8'hF0; a[15:8] = 8'h81; b[15:8] = 8'h01;
    run(2'd0, 2'd0, a, b, 1'b0, '0, 1'b0, 1'b0);
    check("R1 byte and", mask_out, 64'h2);
    // R2: word lane 1 is bits 31:16
    a = '0; b = '0; a[31] = 1'b1; b[31] = 1'b1;
    run(2'd1, 2'd0, a, b, 1'b0, '0, 1'b0, 1'b0);
    check("R2 word slice", mask_out, 64'h2);
    // R3 lane counts
    run(2'd0, 2'd2, ones, ones, 1'b0, '0, 1'b0, 1'b0);
    check("R3 64 byte lanes", mask_out, '1);
    run(2'd3, 2'd0, ones, ones, 1'b0, '0, 1'b0, 1'b0);
    check("R3 2 qword lanes", mask_out, 64'h3);
    run(2'd2, 2'd1, ones, ones, 1'b0, '0, 1'b0, 1'b0);
    check("R3 8 dword lanes", mask_out, 64'hFF);
    // R4 reserved length
    run(2'd0, 2'd3, ones, ones, 1'b0, '0, 1'b0, 1'b0);
    check("R4 reserved length", mask_out, '0);
    // R5 zeroing writemask
    run(2'd0, 2'd2, ones, ones, 1'b1, 64'hA5A5_0000_FFFF_1234, 1'b0, 1'b0);
    check("R5 zeroing", mask_out, 64'hA5A5_0000_FFFF_1234);
    // R6 writemask disabled
    run(2'd0, 2'd0, ones, ones, 1'b0, '0, 1'b0, 1'b0);
    check("R6 wm ignored", mask_out, 64'hFFFF);
    // R7 broadcast dword / qword
    b = '0; b[0] = 1'b1;
    run(2'd2, 2'd2, ones, b, 1'b0, '0, 1'b1, 1'b1);
    check("R7 dword bcast", mask_out, 64'hFFFF);
    b = '0; b[40] = 1'b1;
    run(2'd3, 2'd1, ones, b, 1'b0, '0, 1'b1, 1'b1);
    check("R7 qword bcast", mask_out, 64'hF);
    // R8 broadcast ignored
    b = '0; b[0] = 1'b1;
    run(2'd0, 2'd2, ones, b, 1'b0, '0, 1'b1, 1'b1);
    check("R8 byte no bcast", mask_out, 64'h1);
    run(2'd1, 2'd2, ones, b, 1'b0, '0, 1'b1, 1'b1);
    check("R8 word no bcast", mask_out, 64'h1);
    run(2'd2, 2'd2, ones, b, 1'b0, '0, 1'b1, 1'b0);
    check("R8 register no bcast", mask_out, 64'h1);
    // R9 bits above 128 ignored
    a = ones; a[127:0] = '0;
    run(2'd0, 2'd0, a, ones, 1'b0, '0, 1'b0, 1'b0);
    check("R9 upper source bits", mask_out, '0);
    // R11 hold without valid
    run(2'd0, 2'd1, ones, ones, 1'b0, '0, 1'b0, 1'b0);
    src1 = '0; elem_sz = 2'd3;
    @(negedge clk);
    check("R11 hold mask", mask_out, 64'hFFFF_FFFF);
    check("R10 valid low", MW'(valid_out), '0);
    // R12 reset mid run
    rst_n = 1'b0;
    @(negedge clk);
    check("R12 reset clears", mask_out, '0);
    rst_n = 1'b1;
    @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule